// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retire and Squash Recovery

This block holds the in-flight instructions of a small out-of-order core in a circular buffer. The rename stage asks for a group of slots each cycle. Every granted slot gets a buffer index and a sequence number from a counter that only moves forward. The execute stage marks slots finished by index. The controller retires finished work strictly from the oldest slot, and it never retires more than the commit width in one cycle.

Execute can also ask for a squash. The request carries a sequence number and the branch outcome. The controller then enters a recovery state that lasts several cycles. Each cycle it drops a few of the youngest slots that are newer than the squash point, and it stops when none are left. A registered feedback bus goes back to the earlier stages every cycle. It carries a done sequence number, a squash pulse, a recovery-in-progress flag, the forwarded branch fields and the count of free slots.

Top module: `rob_commit_top`

## Requirements
- R1: Synchronous reset leaves the status Idle (code 0), every feedback flag at 0, the free count equal to DEPTH and the mispredict counter at 0. The first cycle after reset moves the status to Running (code 1).
- R2: A rename request for n slots (1 to REN_W) is granted in the same cycle only if n is no more than the free count before that cycle. Otherwise the whole group is refused. A granted group takes consecutive indices starting at the reported tail index, and consecutive sequence numbers starting at the reported next sequence number.
- R3: Outside recovery, up to CMT_W slots retire each cycle from the oldest. Retirement stops at the first slot not yet marked finished. The next cycle reports the retire count and the sequence number of the oldest retired slot, or 0 when none retire.
- R4: A squash request outside recovery takes priority over rename and retire in that cycle, which grant and retire nothing. The next cycle shows status Squashing (code 2), done sequence number equal to the requested one, squash and in-progress flags high, and the mispredict, taken, next-PC and mispredicted-PC fields copied unchanged from the request.
- R5: In each recovery cycle that still has work, at most SQ_STEP of the youngest slots are dropped, and only those newer than the squash point. The next cycle shows the in-progress flag high and the squash flag low. It also shows the sequence number of the youngest remaining slot as the done number, or the squash number if the buffer is now empty.
- R6: Recovery ends when the buffer is empty or its youngest slot is not newer than the squash point. In that cycle the status returns to Running and all feedback flags are low.
- R7: While the status is Squashing, no rename request is granted, no slot retires, and a new squash request has no effect.
- R8: The free-slot count equals DEPTH minus the number of occupied slots after every cycle, whatever the status.
- R9: The mispredict counter increases by one on each accepted squash whose mispredict flag is set, and is otherwise unchanged.
- R10: Sequence numbers are 8 bits wide and wrap. "Newer" means the 8-bit difference, read as a signed value, is positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_n | input | $clog2(REN_W+1) | Number of slots requested by rename |
| alloc_grant | output | 1 | Rename group accepted this cycle |
| alloc_idx | output | $clog2(DEPTH) | Index of the first slot of the group |
| alloc_seq | output | 8 | Sequence number of the first slot of the group |
| cpl_valid | input | CPL_W | Per-lane finish strobes |
| cpl_idx | input | CPL_W*$clog2(DEPTH) | Per-lane slot index to mark finished |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | 8 | Squash point; newer slots are dropped |
| sq_mispredict | input | 1 | Request carries a mispredict |
| sq_taken | input | 1 | Branch taken |
| sq_next_pc | input | 32 | Redirect PC |
| sq_mispred_pc | input | 32 | PC of the mispredicted branch |
| status | output | 2 | 0 Idle, 1 Running, 2 Squashing |
| fb_done_seq | output | 8 | Feedback done sequence number |
| fb_squash | output | 1 | Feedback squash pulse |
| fb_squashing | output | 1 | Feedback recovery-in-progress flag |
| fb_mispredict | output | 1 | Forwarded mispredict flag |
| fb_taken | output | 1 | Forwarded taken flag |
| fb_next_pc | output | 32 | Forwarded redirect PC |
| fb_mispred_pc | output | 32 | Forwarded mispredicted PC |
| fb_free | output | $clog2(DEPTH)+1 | Free slots |
| cmt_n | output | $clog2(CMT_W+1) | Slots retired last cycle |
| cmt_seq | output | 8 | Sequence number of oldest slot retired last cycle |
| mispred_cnt | output | MC_W | Mispredict squash count |

## Verification
The bench builds the block with DEPTH=8, REN_W=3, CMT_W=2, CPL_W=2 and SQ_STEP=2. The shallow buffer fills within a few cycles, so partial-group refusals and full-buffer stalls happen often. A three-wide rename against an eight-slot buffer leaves remainders that do not divide evenly. With a two-slot squash step, deep squashes span several recovery cycles. Thousands of random cycles push the 8-bit sequence counter through many wraps, so the newer-than comparison is exercised across the wrap point.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int SEQ_W = 8;
    localparam int PC_W  = 32;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [PC_W-1:0]  pc_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_SQUASH  = 2'd2
    } rob_status_e;

    typedef struct packed {
        seq_t done_seq;
        logic squash;
        logic squashing;
        logic mispredict;
        logic taken;
        pc_t  next_pc;
        pc_t  mispred_pc;
    } fb_t;

    // a is newer than b under wrapping arithmetic
    function automatic logic seq_younger(input seq_t a, input seq_t b);
        seq_t d;
        d = a - b;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

endpackage

// File: rtl/rob_entries.sv
module rob_entries
    import rob_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int REN_W   = 2,
    parameter int CMT_W   = 2,
    parameter int CPL_W   = 2,
    parameter int SQ_STEP = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [$clog2(REN_W+1)-1:0]          alloc_n,
    input  seq_t                                alloc_seq0,
    input  logic [$clog2(CMT_W+1)-1:0]          commit_n,
    input  logic [$clog2(SQ_STEP+1)-1:0]        pop_n,
    input  logic [CPL_W-1:0]                    cpl_valid,
    input  logic [CPL_W*$clog2(DEPTH)-1:0]      cpl_idx,
    output logic [CMT_W-1:0]                    head_done,
    output seq_t                                head_seq,
    output logic [SQ_STEP:0][SEQ_W-1:0]         tail_seq,
    output logic [$clog2(DEPTH)-1:0]            tail_idx,
    output logic [$clog2(DEPTH):0]              count
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;
    localparam int AN_W  = $clog2(REN_W+1);
    localparam int WIN   = SQ_STEP + 1;

    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;
    seq_t             seq_q [DEPTH];
    logic [DEPTH-1:0] done_q;
    logic [CPL_W-1:0] cpl_hit;

    // a finish strobe only lands on a slot that is currently occupied
    always_comb begin
        for (int p = 0; p < CPL_W; p++) begin
            logic [IDX_W-1:0] off;
            off = cpl_idx[p*IDX_W +: IDX_W] - head_q;
            cpl_hit[p] = ({1'b0, off} < count_q);
        end
    end

    always_comb begin
        for (int k = 0; k < CMT_W; k++)
            head_done[k] = (CNT_W'(k) < count_q) && done_q[head_q + IDX_W'(k)];
        for (int k = 0; k < WIN; k++)
            tail_seq[k] = seq_q[tail_q - IDX_W'(k + 1)];
    end

    assign head_seq = seq_q[head_q];
    assign tail_idx = tail_q;
    assign count    = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            done_q  <= '0;
        end else begin
            for (int p = 0; p < CPL_W; p++)
                if (cpl_valid[p] && cpl_hit[p])
                    done_q[cpl_idx[p*IDX_W +: IDX_W]] <= 1'b1;
            for (int k = 0; k < REN_W; k++) begin
                if (AN_W'(k) < alloc_n) begin
                    seq_q[tail_q + IDX_W'(k)]  <= alloc_seq0 + SEQ_W'(k);
                    done_q[tail_q + IDX_W'(k)] <= 1'b0;
                end
            end
            head_q  <= head_q + IDX_W'(commit_n);
            tail_q  <= tail_q + IDX_W'(alloc_n) - IDX_W'(pop_n);
            count_q <= count_q + CNT_W'(alloc_n) - CNT_W'(commit_n) - CNT_W'(pop_n);
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    a_r5_pop_bounded: assert property (@(posedge clk) disable iff (rst)
        (CNT_W'(pop_n) + CNT_W'(commit_n)) <= count_q);

endmodule

// File: rtl/rob_commit_ctl.sv
module rob_commit_ctl
    import rob_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int REN_W   = 2,
    parameter int CMT_W   = 2,
    parameter int SQ_STEP = 2,
    parameter int MC_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [$clog2(REN_W+1)-1:0]     ren_n,
    input  logic                           sq_valid,
    input  seq_t                           sq_seq,
    input  logic                           sq_mispredict,
    input  logic                           sq_taken,
    input  pc_t                            sq_next_pc,
    input  pc_t                            sq_mispred_pc,
    input  logic [CMT_W-1:0]               head_done,
    input  seq_t                           head_seq,
    input  logic [SQ_STEP:0][SEQ_W-1:0]    tail_seq,
    input  logic [$clog2(DEPTH):0]         count,
    output logic [$clog2(REN_W+1)-1:0]     alloc_n,
    output seq_t                           alloc_seq0,
    output logic                           grant,
    output logic [$clog2(CMT_W+1)-1:0]     commit_n,
    output logic [$clog2(SQ_STEP+1)-1:0]   pop_n,
    output rob_status_e                    status,
    output fb_t                            fb,
    output logic [$clog2(CMT_W+1)-1:0]     cmt_n,
    output seq_t                           cmt_seq,
    output logic [MC_W-1:0]                mispred_cnt
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam int AN_W  = $clog2(REN_W+1);
    localparam int CN_W  = $clog2(CMT_W+1);
    localparam int PN_W  = $clog2(SQ_STEP+1);

    rob_status_e      status_q, status_d;
    fb_t              fb_q, fb_d;
    seq_t             hold_q, nseq_q, step_seq, cmt_seq_q;
    logic [CN_W-1:0]  cmt_n_q;
    logic [MC_W-1:0]  mcnt_q;
    logic [CNT_W-1:0] free_cnt;
    logic             normal, accept, finished, run_c, run_p;

    always_comb begin
        normal   = (status_q != ST_SQUASH);
        accept   = normal && sq_valid;
        free_cnt = CNT_W'(DEPTH) - count;
        grant    = normal && !sq_valid && (ren_n != '0) && (CNT_W'(ren_n) <= free_cnt);
        alloc_n  = grant ? ren_n : AN_W'(0);

        // in-order retire: stop at first unfinished slot
        commit_n = '0;
        run_c    = normal && !sq_valid;
        for (int k = 0; k < CMT_W; k++) begin
            if (run_c && head_done[k]) commit_n = commit_n + CN_W'(1);
            else                       run_c    = 1'b0;
        end

        // recovery step: peel newest slots that lie beyond the squash point
        finished = (count == '0) || !seq_younger(tail_seq[0], hold_q);
        pop_n    = '0;
        run_p    = !normal && !finished;
        for (int k = 0; k < SQ_STEP; k++) begin
            if (run_p && (CNT_W'(k) < count) && seq_younger(tail_seq[k], hold_q))
                pop_n = pop_n + PN_W'(1);
            else
                run_p = 1'b0;
        end
        step_seq = (CNT_W'(pop_n) < count) ? tail_seq[pop_n] : hold_q;

        fb_d = '0;
        if (accept) begin
            fb_d.done_seq   = sq_seq;
            fb_d.squash     = 1'b1;
            fb_d.squashing  = 1'b1;
            fb_d.mispredict = sq_mispredict;
            fb_d.taken      = sq_taken;
            fb_d.next_pc    = sq_next_pc;
            fb_d.mispred_pc = sq_mispred_pc;
        end else if (!normal && !finished) begin
            fb_d.done_seq   = step_seq;
            fb_d.squashing  = 1'b1;
        end

        case (status_q)
            ST_SQUASH: status_d = finished ? ST_RUN : ST_SQUASH;
            default:   status_d = accept ? ST_SQUASH : ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q  <= ST_IDLE;
            fb_q      <= '0;
            hold_q    <= '0;
            nseq_q    <= '0;
            cmt_n_q   <= '0;
            cmt_seq_q <= '0;
            mcnt_q    <= '0;
        end else begin
            status_q  <= status_d;
            fb_q      <= fb_d;
            nseq_q    <= nseq_q + SEQ_W'(alloc_n);
            cmt_n_q   <= commit_n;
            cmt_seq_q <= (commit_n != '0) ? head_seq : '0;
            if (accept) begin
                hold_q <= sq_seq;
                if (sq_mispredict) mcnt_q <= mcnt_q + MC_W'(1);
            end
        end
    end

    assign alloc_seq0  = nseq_q;
    assign status      = status_q;
    assign fb          = fb_q;
    assign cmt_n       = cmt_n_q;
    assign cmt_seq     = cmt_seq_q;
    assign mispred_cnt = mcnt_q;

    a_r4_enter_recovery: assert property (@(posedge clk) disable iff (rst)
        accept |=> (status_q == ST_SQUASH && fb_q.squash && fb_q.squashing));

    a_r6_exit_when_empty: assert property (@(posedge clk) disable iff (rst)
        (status_q == ST_SQUASH && count == '0) |=> (status_q == ST_RUN && !fb_q.squashing));

    a_r9_counter_quiet: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(mcnt_q));

endmodule

// File: rtl/rob_commit_top.sv
module rob_commit_top
    import rob_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int REN_W   = 2,
    parameter int CMT_W   = 2,
    parameter int CPL_W   = 2,
    parameter int SQ_STEP = 2,
    parameter int MC_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [$clog2(REN_W+1)-1:0]       ren_n,
    output logic                             alloc_grant,
    output logic [$clog2(DEPTH)-1:0]         alloc_idx,
    output logic [SEQ_W-1:0]                 alloc_seq,
    input  logic [CPL_W-1:0]                 cpl_valid,
    input  logic [CPL_W*$clog2(DEPTH)-1:0]   cpl_idx,
    input  logic                             sq_valid,
    input  logic [SEQ_W-1:0]                 sq_seq,
    input  logic                             sq_mispredict,
    input  logic                             sq_taken,
    input  logic [PC_W-1:0]                  sq_next_pc,
    input  logic [PC_W-1:0]                  sq_mispred_pc,
    output logic [1:0]                       status,
    output logic [SEQ_W-1:0]                 fb_done_seq,
    output logic                             fb_squash,
    output logic                             fb_squashing,
    output logic                             fb_mispredict,
    output logic                             fb_taken,
    output logic [PC_W-1:0]                  fb_next_pc,
    output logic [PC_W-1:0]                  fb_mispred_pc,
    output logic [$clog2(DEPTH):0]           fb_free,
    output logic [$clog2(CMT_W+1)-1:0]       cmt_n,
    output logic [SEQ_W-1:0]                 cmt_seq,
    output logic [MC_W-1:0]                  mispred_cnt
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic [$clog2(REN_W+1)-1:0]   alloc_n;
    logic [$clog2(CMT_W+1)-1:0]   commit_n;
    logic [$clog2(SQ_STEP+1)-1:0] pop_n;
    seq_t                         alloc_seq0, head_seq;
    logic [CMT_W-1:0]             head_done;
    logic [SQ_STEP:0][SEQ_W-1:0]  tail_seq;
    logic [CNT_W-1:0]             count;
    rob_status_e                  st;
    fb_t                          fb;

    rob_entries #(
        .DEPTH(DEPTH), .REN_W(REN_W), .CMT_W(CMT_W),
        .CPL_W(CPL_W), .SQ_STEP(SQ_STEP)
    ) u_entries (
        .clk(clk), .rst(rst),
        .alloc_n(alloc_n), .alloc_seq0(alloc_seq0),
        .commit_n(commit_n), .pop_n(pop_n),
        .cpl_valid(cpl_valid), .cpl_idx(cpl_idx),
        .head_done(head_done), .head_seq(head_seq),
        .tail_seq(tail_seq), .tail_idx(alloc_idx), .count(count)
    );

    rob_commit_ctl #(
        .DEPTH(DEPTH), .REN_W(REN_W), .CMT_W(CMT_W),
        .SQ_STEP(SQ_STEP), .MC_W(MC_W)
    ) u_ctl (
        .clk(clk), .rst(rst),
        .ren_n(ren_n), .sq_valid(sq_valid), .sq_seq(sq_seq),
        .sq_mispredict(sq_mispredict), .sq_taken(sq_taken),
        .sq_next_pc(sq_next_pc), .sq_mispred_pc(sq_mispred_pc),
        .head_done(head_done), .head_seq(head_seq),
        .tail_seq(tail_seq), .count(count),
        .alloc_n(alloc_n), .alloc_seq0(alloc_seq0), .grant(alloc_grant),
        .commit_n(commit_n), .pop_n(pop_n), .status(st), .fb(fb),
        .cmt_n(cmt_n), .cmt_seq(cmt_seq), .mispred_cnt(mispred_cnt)
    );

    assign alloc_seq     = alloc_seq0;
    assign status        = st;
    assign fb_done_seq   = fb.done_seq;
    assign fb_squash     = fb.squash;
    assign fb_squashing  = fb.squashing;
    assign fb_mispredict = fb.mispredict;
    assign fb_taken      = fb.taken;
    assign fb_next_pc    = fb.next_pc;
    assign fb_mispred_pc = fb.mispred_pc;
    assign fb_free       = CNT_W'(DEPTH) - count;

    a_r7_quiet_in_recovery: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SQUASH) |-> (alloc_n == '0 && commit_n == '0));

    a_r8_free_in_range: assert property (@(posedge clk) disable iff (rst)
        fb_free <= CNT_W'(DEPTH));

endmodule

// File: tb/rob_commit_top_tb.sv
module rob_commit_top_tb;
    localparam int D   = 8;
    localparam int RW  = 3;
    localparam int CW  = 2;
    localparam int PW  = 2;
    localparam int SS  = 2;
    localparam int MW  = 8;
    localparam int IW  = $clog2(D);
    localparam int CNW = IW + 1;
    localparam int RNW = $clog2(RW+1);
    localparam int CMW = $clog2(CW+1);

    logic clk = 1'b0;
    logic rst;
    logic [RNW-1:0]   ren_n;
    logic             alloc_grant;
    logic [IW-1:0]    alloc_idx;
    logic [7:0]       alloc_seq;
    logic [PW-1:0]    cpl_valid;
    logic [PW*IW-1:0] cpl_idx;
    logic             sq_valid, sq_mispredict, sq_taken;
    logic [7:0]       sq_seq;
    logic [31:0]      sq_next_pc, sq_mispred_pc;
    logic [1:0]       status;
    logic [7:0]       fb_done_seq;
    logic             fb_squash, fb_squashing, fb_mispredict, fb_taken;
    logic [31:0]      fb_next_pc, fb_mispred_pc;
    logic [CNW-1:0]   fb_free;
    logic [CMW-1:0]   cmt_n;
    logic [7:0]       cmt_seq;
    logic [MW-1:0]    mispred_cnt;

    rob_commit_top #(.DEPTH(D), .REN_W(RW), .CMT_W(CW), .CPL_W(PW),
                     .SQ_STEP(SS), .MC_W(MW)) u_dut (
        .clk(clk), .rst(rst), .ren_n(ren_n), .alloc_grant(alloc_grant),
        .alloc_idx(alloc_idx), .alloc_seq(alloc_seq),
        .cpl_valid(cpl_valid), .cpl_idx(cpl_idx),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_mispredict(sq_mispredict),
        .sq_taken(sq_taken), .sq_next_pc(sq_next_pc), .sq_mispred_pc(sq_mispred_pc),
        .status(status), .fb_done_seq(fb_done_seq), .fb_squash(fb_squash),
        .fb_squashing(fb_squashing), .fb_mispredict(fb_mispredict),
        .fb_taken(fb_taken), .fb_next_pc(fb_next_pc), .fb_mispred_pc(fb_mispred_pc),
        .fb_free(fb_free), .cmt_n(cmt_n), .cmt_seq(cmt_seq), .mispred_cnt(mispred_cnt)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // behavioural reference
    int m_status;
    int mseq[$];
    bit mdone[$];
    int hidx, tidx, nseq, hold, mcnt;
    int e_done, e_sq, e_sqg, e_mp, e_tk, e_cn, e_cs;
    longint e_npc, e_mpc;

    // drive values for the next cycle
    int d_ren;
    bit d_cv[PW];
    int d_ci[PW];
    bit d_sqv, d_mp, d_tk;
    int d_sqs;
    longint d_npc, d_mpc;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit yg(input int a, input int b);
        int d;
        d = (a - b) & 255;
        return (d > 0) && (d < 128);
    endfunction

    task automatic quiet();
        d_ren = 0; d_sqv = 0; d_mp = 0; d_tk = 0; d_sqs = 0; d_npc = 0; d_mpc = 0;
        for (int p = 0; p < PW; p++) begin d_cv[p] = 0; d_ci[p] = 0; end
    endtask

    task automatic step();
        int sz, cn, fr, pos;
        bit nrm, acc, gr, fin;
        @(negedge clk);
        ren_n = RNW'(d_ren);
        for (int p = 0; p < PW; p++) begin
            cpl_valid[p] = d_cv[p];
            cpl_idx[p*IW +: IW] = IW'(d_ci[p]);
        end
        sq_valid = d_sqv; sq_seq = 8'(d_sqs); sq_mispredict = d_mp; sq_taken = d_tk;
        sq_next_pc = 32'(d_npc); sq_mispred_pc = 32'(d_mpc);
        #1;
        sz  = mseq.size();
        nrm = (m_status != 2);
        acc = nrm && d_sqv;
        fr  = D - sz;
        gr  = nrm && !d_sqv && d_ren > 0 && d_ren <= fr;
        chk("R2 R7 grant", alloc_grant, gr);
        chk("R2 tail index", alloc_idx, tidx);
        chk("R2 next seq", alloc_seq, nseq);

        cn = 0;
        if (nrm && !d_sqv)
            for (int k = 0; k < CW; k++)
                if (k < sz && mdone[k] && cn == k) cn++;
        for (int p = 0; p < PW; p++)
            if (d_cv[p]) begin
                pos = (d_ci[p] - hidx + D) % D;
                if (pos < sz) mdone[pos] = 1;
            end
        e_done = 0; e_sq = 0; e_sqg = 0; e_mp = 0; e_tk = 0; e_npc = 0; e_mpc = 0;
        e_cn = 0; e_cs = 0;
        if (acc) begin
            m_status = 2; hold = d_sqs;
            e_done = d_sqs; e_sq = 1; e_sqg = 1; e_mp = d_mp; e_tk = d_tk;
            e_npc = d_npc; e_mpc = d_mpc;
            if (d_mp) mcnt = (mcnt + 1) & 255;
        end else if (m_status == 2) begin
            fin = (sz == 0) || !yg(mseq[sz-1], hold);
            if (fin) m_status = 1;
            else begin
                for (int k = 0; k < SS; k++) begin
                    if (mseq.size() > 0 && yg(mseq[mseq.size()-1], hold)) begin
                        void'(mseq.pop_back()); void'(mdone.pop_back());
                        tidx = (tidx + D - 1) % D;
                    end else break;
                end
                e_done = (mseq.size() > 0) ? mseq[mseq.size()-1] : hold;
                e_sqg = 1;
            end
        end else begin
            m_status = 1;
            if (gr) begin
                for (int k = 0; k < d_ren; k++) begin
                    mseq.push_back((nseq + k) & 255); mdone.push_back(0);
                end
                tidx = (tidx + d_ren) % D;
                nseq = (nseq + d_ren) & 255;
            end
            e_cn = cn;
            if (cn > 0) e_cs = mseq[0];
            for (int k = 0; k < cn; k++) begin
                void'(mseq.pop_front()); void'(mdone.pop_front());
            end
            hidx = (hidx + cn) % D;
        end

        @(posedge clk);
        #1;
        chk("R1 R4 R6 status", status, m_status);
        chk("R5 R10 done seq", fb_done_seq, e_done);
        chk("R4 R5 squash flag", fb_squash, e_sq);
        chk("R5 R6 squashing flag", fb_squashing, e_sqg);
        chk("R4 fwd mispredict", fb_mispredict, e_mp);
        chk("R4 fwd taken", fb_taken, e_tk);
        chk("R4 fwd next pc", fb_next_pc, e_npc);
        chk("R4 fwd mispred pc", fb_mispred_pc, e_mpc);
        chk("R8 free count", fb_free, D - mseq.size());
        chk("R3 R7 retire count", cmt_n, e_cn);
        chk("R3 retire seq", cmt_seq, e_cs);
        chk("R9 mispredict count", mispred_cnt, mcnt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        quiet();
        ren_n = '0; cpl_valid = '0; cpl_idx = '0; sq_valid = 0; sq_seq = '0;
        sq_mispredict = 0; sq_taken = 0; sq_next_pc = '0; sq_mispred_pc = '0;
        rst = 1'b1;
        m_status = 0; hidx = 0; tidx = 0; nseq = 0; hold = 0; mcnt = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 reset status", status, 0);
        chk("R1 reset free", fb_free, D);
        chk("R1 reset flags", {fb_squash, fb_squashing}, 0);
        chk("R1 reset counter", mispred_cnt, 0);
        @(negedge clk);
        rst = 1'b0;

        // R1 Idle to Running
        step();
        // R2 fill: 3 + 3, then 3 refused with 2 free, then 2 accepted, then 1 refused when full
        d_ren = 3; step();
        d_ren = 3; step();
        d_ren = 3; step();
        d_ren = 2; step();
        d_ren = 1; step();
        d_ren = 0;
        // R3 out-of-order finish: slots 1 and 2 done, head not yet
        d_cv[0] = 1; d_ci[0] = 1; d_cv[1] = 1; d_ci[1] = 2; step();
        quiet(); step();
        d_cv[0] = 1; d_ci[0] = 0; step();
        quiet(); step(); step(); step();
        // R4 squash with mispredict at the second-oldest slot
        d_sqv = 1; d_sqs = mseq[1]; d_mp = 1; d_tk = 1;
        d_npc = 32'h0000_4F00; d_mpc = 32'h0000_4E80; d_ren = 2; step();
        // R7 squash and rename during recovery are ignored
        quiet(); d_sqv = 1; d_sqs = 0; d_mp = 1; d_ren = 1; step();
        quiet();
        repeat (4) step();

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            int sz;
            quiet();
            sz = mseq.size();
            d_ren = $urandom % (RW + 1);
            for (int p = 0; p < PW; p++)
                if (sz > 0 && ($urandom % 10) < 6) begin
                    d_cv[p] = 1;
                    d_ci[p] = (hidx + ($urandom % sz)) % D;
                end
            if (($urandom % 100) < 4) begin
                d_sqv = 1;
                d_mp  = $urandom % 2;
                d_tk  = $urandom % 2;
                d_npc = $urandom;
                d_mpc = $urandom;
                if (sz == 0)                  d_sqs = (nseq + 255) & 255;
                else if ($urandom % 4 == 0)   d_sqs = (mseq[0] + 255) & 255;
                else                          d_sqs = mseq[$urandom % sz];
            end
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule